// File: doc/BRIEF.md
# Conversion Result Half-Word Packer

This block sits between a converter's result stream and the data word that a bus reader fetches. Each 16-bit result arrives as a one-cycle strobe. Under a 2-bit packing mode, the block places the result into the upper or lower half of a 32-bit word. It either finishes a word with every result, or it pairs two results into one word. When two converters run side by side, a source tag on each result decides which half the result lands in. The master's result always takes the half that is filled first.

The block shows which half will receive the next result, and it keeps a flag that says a completed word is waiting. A conversion-complete status bit is set when a word completes. Software may also clear or force that bit, and the interrupt line is the bit gated by its enable. Only the write that completes a word updates the visible data word, the ready flag and the status bit. A half that is only partly filled stays hidden inside the block.

Top module: `adcpk_top`

## Requirements
- R1: After a synchronous reset, `data_o` is 0 and `ready_o` and `cc_flag_o` are 0. With `mode_i` = 0, `upper_next_o` is 1.
- R2: With `mode_i` = 0 (upper only), each result completes a word equal to {result, 16'h0000}.
- R3: With `mode_i` = 1 (lower only), each result completes a word equal to {16'h0000, result}.
- R4: With `mode_i` = 2 (upper first), the first result of a pair is held back and `data_o` does not change. The second result completes the word {first, second}.
- R5: With `mode_i` = 3 (lower first), the second result of a pair completes the word {second, first}.
- R6: With `sim_en_i` = 1 in mode 2 or 3, a result with `res_slave_i` = 0 (master) goes to the first-filled half and a result with `res_slave_i` = 1 (slave) goes to the other half. The slave write completes the word.
- R7: `upper_next_o` is 1 when the next result will land in the upper half and 0 when it will land in the lower half.
- R8: `ready_o` rises in the cycle after a completed word and falls in the cycle after `rd_i`. When both happen in the same cycle, the completion wins.
- R9: `cc_flag_o` is set by a completed word. A software write (`flag_we_i`) loads `flag_wr_i`, where 0 clears the bit and 1 sets it. A completion in the same cycle as a software clear wins. `irq_o` is `cc_flag_o` AND `cc_ie_i`.
- R10: A change of `mode_i` returns the packing pointer to the first half of the new mode and discards any half-filled word. This also holds when a result arrives in the cycle of the change.
- R11: In a cycle without `res_valid_i`, `data_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Packing mode (0 upper only, 1 lower only, 2 upper first, 3 lower first) |
| sim_en_i | input | 1 | Simultaneous two-converter packing enable |
| cc_ie_i | input | 1 | Conversion-complete interrupt enable |
| res_valid_i | input | 1 | Result strobe |
| res_slave_i | input | 1 | Result comes from the slave converter |
| res_data_i | input | 16 | Conversion result |
| rd_i | input | 1 | Bus read of the data word |
| flag_we_i | input | 1 | Software write to the status bit |
| flag_wr_i | input | 1 | Value written to the status bit |
| data_o | output | 32 | Last completed data word |
| upper_next_o | output | 1 | Next result goes to the upper half |
| ready_o | output | 1 | A completed word is waiting |
| cc_flag_o | output | 1 | Conversion-complete status bit |
| irq_o | output | 1 | Conversion-complete interrupt |

## Verification
Two pairs of events can fall in the same cycle. A completing result can meet a bus read, which fights over the ready flag. A completing result can also meet a software clear, which fights over the status bit. The bench drives both pairs deliberately on the very edge where a pair completes, and it expects the set to win in each case. A third collision is a mode change arriving together with a result. The bench judges it by the next completed word, which must hold only results from after the change.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        PK_UPPER_ONLY  = 2'd0,
        PK_LOWER_ONLY  = 2'd1,
        PK_UPPER_FIRST = 2'd2,
        PK_LOWER_FIRST = 2'd3
    } pack_mode_e;

    typedef struct packed {
        logic              done;
        logic [WORD_W-1:0] word;
    } pack_res_t;

    function automatic logic first_is_upper(input pack_mode_e m);
        return (m == PK_UPPER_ONLY) || (m == PK_UPPER_FIRST);
    endfunction

    function automatic logic is_paired(input pack_mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/adcpk_lane.sv
module adcpk_lane
    import adcpk_pkg::*;
#(
    parameter int HW = HALF_W,
    localparam int WW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_i,
    input  logic          sim_en_i,
    input  logic          valid_i,
    input  logic          slave_i,
    input  logic [HW-1:0] data_i,
    output logic          done_o,
    output logic [WW-1:0] word_o,
    output logic          upper_next_o
);
    pack_mode_e    mode_q;
    pack_mode_e    mode_now;
    logic          pend_q;
    logic [HW-1:0] stage_q;
    logic [WW-1:0] word_q;

    logic          mode_chg;
    logic          pend_eff;
    logic [HW-1:0] stage_eff;
    logic          fu;
    logic          to_second;
    logic [WW-1:0] word_nx;

    always_comb begin
        mode_now  = pack_mode_e'(mode_i);
        mode_chg  = (mode_now != mode_q);
        pend_eff  = pend_q & ~mode_chg;
        stage_eff = mode_chg ? '0 : stage_q;
        fu        = first_is_upper(mode_now);
        to_second = sim_en_i ? slave_i : pend_eff;
        done_o    = 1'b0;
        word_nx   = word_q;
        if (valid_i) begin
            if (!is_paired(mode_now)) begin
                done_o  = 1'b1;
                word_nx = fu ? {data_i, {HW{1'b0}}} : {{HW{1'b0}}, data_i};
            end else if (to_second) begin
                done_o  = 1'b1;
                word_nx = fu ? {stage_eff, data_i} : {data_i, stage_eff};
            end
        end
        upper_next_o = is_paired(mode_now) ? (fu ^ pend_eff) : fu;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= PK_UPPER_ONLY;
            pend_q  <= 1'b0;
            stage_q <= '0;
            word_q  <= '0;
        end else begin
            mode_q <= mode_now;
            word_q <= word_nx;
            if (valid_i && is_paired(mode_now) && !to_second) begin
                pend_q  <= 1'b1;
                stage_q <= data_i;
            end else if (done_o || mode_chg) begin
                pend_q  <= 1'b0;
                stage_q <= '0;
            end
        end
    end

    assign word_o = word_q;

    p_hold_first_r4: assert property (@(posedge clk) disable iff (rst)
        valid_i && is_paired(mode_now) && !to_second |=> $stable(word_q));
endmodule

// File: rtl/adcpk_flags.sv
module adcpk_flags (
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic rd_i,
    input  logic flag_we_i,
    input  logic flag_wr_i,
    input  logic ie_i,
    output logic ready_o,
    output logic flag_o,
    output logic irq_o
);
    logic ready_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (done_i)    ready_q <= 1'b1;
            else if (rd_i) ready_q <= 1'b0;
            if (done_i)         flag_q <= 1'b1;
            else if (flag_we_i) flag_q <= flag_wr_i;
        end
    end

    assign ready_o = ready_q;
    assign flag_o  = flag_q;
    assign irq_o   = flag_q & ie_i;

    p_done_ready_r8: assert property (@(posedge clk) disable iff (rst)
        done_i |=> ready_o);
    p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
        rd_i && !done_i |=> !ready_o);
    p_done_flag_r9: assert property (@(posedge clk) disable iff (rst)
        done_i |=> flag_o);
endmodule

// File: rtl/adcpk_top.sv
module adcpk_top
    import adcpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              sim_en_i,
    input  logic              cc_ie_i,
    input  logic              res_valid_i,
    input  logic              res_slave_i,
    input  logic [HALF_W-1:0] res_data_i,
    input  logic              rd_i,
    input  logic              flag_we_i,
    input  logic              flag_wr_i,
    output logic [WORD_W-1:0] data_o,
    output logic              upper_next_o,
    output logic              ready_o,
    output logic              cc_flag_o,
    output logic              irq_o
);
    pack_res_t lane_res;

    adcpk_lane #(.HW(HALF_W)) u_lane (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode_i),
        .sim_en_i     (sim_en_i),
        .valid_i      (res_valid_i),
        .slave_i      (res_slave_i),
        .data_i       (res_data_i),
        .done_o       (lane_res.done),
        .word_o       (lane_res.word),
        .upper_next_o (upper_next_o)
    );

    adcpk_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .done_i    (lane_res.done),
        .rd_i      (rd_i),
        .flag_we_i (flag_we_i),
        .flag_wr_i (flag_wr_i),
        .ie_i      (cc_ie_i),
        .ready_o   (ready_o),
        .flag_o    (cc_flag_o),
        .irq_o     (irq_o)
    );

    assign data_o = lane_res.word;

    p_upper_only_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid_i && mode_i == 2'd0 |=> data_o[HALF_W-1:0] == '0);
    p_lower_only_r3: assert property (@(posedge clk) disable iff (rst)
        res_valid_i && mode_i == 2'd1 |=> data_o[WORD_W-1:HALF_W] == '0);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !res_valid_i |=> $stable(data_o));
endmodule

// File: tb/test_adcpk_top.sv
module test_adcpk_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'd0;
    logic        sim_en_i = 1'b0, cc_ie_i = 1'b0;
    logic        res_valid_i = 1'b0, res_slave_i = 1'b0;
    logic [15:0] res_data_i = 16'h0;
    logic        rd_i = 1'b0, flag_we_i = 1'b0, flag_wr_i = 1'b0;
    logic [31:0] data_o;
    logic        upper_next_o, ready_o, cc_flag_o, irq_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_data;
    logic [15:0] m_stage;
    logic [1:0]  m_mode;
    logic        m_pend, m_ready, m_flag;

    always #5 clk = ~clk;

    adcpk_top i_adcpk_top (
        .clk(clk), .rst(rst), .mode_i(mode_i), .sim_en_i(sim_en_i),
        .cc_ie_i(cc_ie_i), .res_valid_i(res_valid_i), .res_slave_i(res_slave_i),
        .res_data_i(res_data_i), .rd_i(rd_i), .flag_we_i(flag_we_i),
        .flag_wr_i(flag_wr_i), .data_o(data_o), .upper_next_o(upper_next_o),
        .ready_o(ready_o), .cc_flag_o(cc_flag_o), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        logic fu, done, second;
        if (rst) begin
            m_data = 0; m_stage = 0; m_mode = 0;
            m_pend = 0; m_ready = 0; m_flag = 0;
        end else begin
            if (mode_i != m_mode) begin m_pend = 0; m_stage = 0; end
            fu = (mode_i == 2'd0) || (mode_i == 2'd2);
            done = 0;
            if (res_valid_i) begin
                if (mode_i < 2) begin
                    done = 1;
                    m_data = fu ? {res_data_i, 16'h0} : {16'h0, res_data_i};
                end else begin
                    second = sim_en_i ? res_slave_i : m_pend;
                    if (second) begin
                        done = 1;
                        m_data = fu ? {m_stage, res_data_i} : {res_data_i, m_stage};
                        m_pend = 0; m_stage = 0;
                    end else begin
                        m_stage = res_data_i; m_pend = 1;
                    end
                end
            end
            if (done) m_ready = 1; else if (rd_i) m_ready = 0;
            if (done) m_flag = 1; else if (flag_we_i) m_flag = flag_wr_i;
            m_mode = mode_i;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic fu, pe, un;
        fu = (mode_i == 2'd0) || (mode_i == 2'd2);
        pe = m_pend && (mode_i == m_mode);
        un = (mode_i < 2) ? fu : (fu ^ pe);
        chk(cur_req, "data_o", data_o, m_data);
        chk("R8", "ready_o", {31'h0, ready_o}, {31'h0, m_ready});
        chk("R9", "cc_flag_o", {31'h0, cc_flag_o}, {31'h0, m_flag});
        chk("R9", "irq_o", {31'h0, irq_o}, {31'h0, m_flag & cc_ie_i});
        chk("R7", "upper_next_o", {31'h0, upper_next_o}, {31'h0, un});
    endtask

    task automatic cyc(input logic v, input logic s, input logic [15:0] d,
                       input logic rd = 0, input logic we = 0, input logic wv = 0);
        @(negedge clk);
        compare();
        res_valid_i = v; res_slave_i = s; res_data_i = d;
        rd_i = rd; flag_we_i = we; flag_wr_i = wv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "data_o", data_o, 32'h0);
        chk("R1", "ready_o", {31'h0, ready_o}, 32'h0);
        chk("R1", "cc_flag_o", {31'h0, cc_flag_o}, 32'h0);
        chk("R1", "upper_next_o", {31'h0, upper_next_o}, 32'h1);

        cur_req = "R2"; cc_ie_i = 1;
        cyc(1, 0, 16'hA1A1); cyc(1, 0, 16'hB2B2); cyc(0, 0, 0, 1); idle(2);

        cur_req = "R3"; mode_i = 2'd1;
        idle(1); cyc(1, 0, 16'h1234); cyc(0, 0, 0); cyc(1, 0, 16'h5678, 1); idle(2);

        cur_req = "R4"; mode_i = 2'd2;
        idle(1); cyc(1, 0, 16'h1111); idle(2); cyc(1, 0, 16'h2222);
        cyc(1, 0, 16'h3333); cyc(1, 0, 16'h4444, 0, 1, 0); idle(2);

        cur_req = "R5"; mode_i = 2'd3;
        idle(1); cyc(1, 0, 16'hC0DE); cyc(1, 0, 16'hBEEF); cyc(0, 0, 0, 1); idle(2);

        cur_req = "R9";
        cyc(0, 0, 0, 0, 1, 0); idle(1); cyc(0, 0, 0, 0, 1, 1); idle(1);
        cc_ie_i = 0; idle(1); cyc(0, 0, 0, 0, 1, 0); cc_ie_i = 1; idle(2);

        cur_req = "R6"; sim_en_i = 1; mode_i = 2'd2;
        idle(1); cyc(1, 0, 16'h0AAA); cyc(1, 1, 16'h0BBB); idle(1);
        mode_i = 2'd3; idle(1); cyc(1, 0, 16'h0CCC); cyc(1, 1, 16'h0DDD); idle(1);
        cyc(1, 1, 16'h0EEE); idle(2); sim_en_i = 0;

        cur_req = "R8";
        cyc(1, 0, 16'h7777); cyc(1, 0, 16'h8888, 1); idle(1);
        cyc(1, 0, 16'h9999, 0, 1, 1); cyc(1, 0, 16'hAAAA, 0, 1, 0); idle(2);

        cur_req = "R10"; mode_i = 2'd2;
        idle(1); cyc(1, 0, 16'hDEAD);
        mode_i = 2'd3; cyc(0, 0, 0); cyc(1, 0, 16'h0101); cyc(1, 0, 16'h0202); idle(1);
        cyc(1, 0, 16'hFACE); mode_i = 2'd2; cyc(1, 0, 16'h0303); cyc(1, 0, 16'h0404); idle(2);

        cur_req = "R11";
        cyc(0, 1, 16'hFFFF); cyc(0, 0, 16'h5555, 0, 0, 0); idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule